// File: doc/BRIEF.md
# Reference Window Fetch Address Generator

This block turns one motion-compensation request into the read commands that fetch its reference window from external SDRAM. In this layout each 4×4 luma sub-block is stored as a vector in two adjacent memory locations. Consecutive rows of sub-blocks are spread across consecutive banks. A request gives the pixel position of the current 4×4 block and a quarter-pel motion vector. The block first works out the reference window. Its size depends on which axes carry a fractional part, because the six-tap filter needs extra pixels on those axes. The window origin is then clamped to the frame.

The block then issues one read command for each sub-block row the window touches, top row first, through a valid/ready handshake. Each command carries the bank, the memory row, the column as sent to the controller, and the burst length. Three select values go out alongside every command: which of the two vectors in the returned group holds the window start, and the horizontal and vertical pixel offsets of the start inside its sub-block. A downstream reassembly stage uses them to cut the window out of the returned words. The block accepts a new request only when the previous command stream has finished.

Top module: `mc_ref_fetch_agu`

## Requirements
- R1: A fractional part (low two vector bits) that is zero on an axis gives a window span of 4 pixels on that axis; a non-zero fraction gives a span of 9 pixels.
- R2: The unclamped window origin on each axis is the block position plus the floor of the vector divided by 4, minus 2 when that axis has a non-zero fraction; negative vectors round toward minus infinity.
- R3: The origin on each axis is clamped to the range 0 to frame size minus span, so the whole window lies inside the frame.
- R4: For sub-block rows first = origin_y/4 to last = (origin_y+span_y−1)/4, exactly one command per row is issued, in ascending order; cmd_last is 1 only on the final one, after which cmd_valid drops and req_ready returns to 1.
- R5: The bank field is the low 3 bits of the sub-block row index; the memory row field is that index shifted right by 3.
- R6: The column field is the first sub-block column index shifted right by 1, i.e. the full column (twice the sub-block index) with its two low bits dropped.
- R7: The burst length, in units of four locations, is (last sub-block column / 2) − (first sub-block column / 2) + 1 and is therefore 1 or 2.
- R8: sel_blk is bit 0 of the first sub-block column, sel_px the low 2 bits of the clamped origin x, and sel_py the low 2 bits of the clamped origin y; all three stay the same across every command of one request.
- R9: While cmd_valid is 1 and cmd_ready is 0, every command output stays unchanged; after reset cmd_valid is 0 and req_ready is 1.
- R10: req_ready is 0 while commands are pending, and a request presented then is ignored: the pending stream continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_blk_x | input | clog2(FRAME_W+1) | Pixel x of the current 4×4 block |
| req_blk_y | input | clog2(FRAME_H+1) | Pixel y of the current 4×4 block |
| req_mv_x | input | MV_W | Signed quarter-pel horizontal vector |
| req_mv_y | input | MV_W | Signed quarter-pel vertical vector |
| cmd_valid | output | 1 | Read command present |
| cmd_ready | input | 1 | Controller takes the command |
| cmd_bank | output | BANK_BITS | Bank of the command |
| cmd_row | output | ROW_BITS | Memory row in the bank |
| cmd_col | output | COL_BITS−2 | Column with the two low bits dropped |
| cmd_burst | output | 2 | Burst length in four-location units |
| cmd_last | output | 1 | Final command of the request |
| sel_blk | output | 1 | Vector of the returned pair that holds the window start |
| sel_px | output | 2 | Horizontal pixel offset of the start in its sub-block |
| sel_py | output | 2 | Vertical pixel offset of the start in its sub-block |

## Verification
The bench builds the block with a 128×96 frame and keeps the default vector width and memory geometry. In that frame the clamps at both edges can be reached from small coordinates. The frame is also tall enough that a nine-row window crosses from bank 7 into bank 0 of the next memory row. Windows that start at both even and odd sub-block columns are covered, which exercises both burst lengths.

// File: rtl/mc_fetch_pkg.sv
package mc_fetch_pkg;

  // Sequencer state.
  typedef enum logic [0:0] {
    SEQ_IDLE  = 1'b0,
    SEQ_ISSUE = 1'b1
  } seq_state_e;

  // Window span on one axis, with and without six-tap support.
  localparam int SPAN_PLAIN  = 4;
  localparam int SPAN_FILTER = 9;
  localparam int FILTER_LEAD = 2;

endpackage

// File: rtl/mc_axis_window.sv
// One axis of the reference window: origin, clamp and sub-block span.
module mc_axis_window
  import mc_fetch_pkg::*;
#(
  parameter int DIM  = 1920,
  parameter int MV_W = 12,
  localparam int C_W  = $clog2(DIM + 1),
  localparam int SB_W = C_W - 2
) (
  input  logic [C_W-1:0]  pos,
  input  logic [MV_W-1:0] mv,
  output logic [C_W-1:0]  org,
  output logic [SB_W-1:0] sb_first,
  output logic [SB_W-1:0] sb_last
);

  localparam int SW = C_W + MV_W + 1;

  logic                 filt;
  logic signed [SW-1:0] s_pos;
  logic signed [SW-1:0] s_mv;
  logic signed [SW-1:0] s_int;
  logic signed [SW-1:0] s_lead;
  logic signed [SW-1:0] s_raw;
  logic signed [SW-1:0] s_lim;
  logic [C_W-1:0]       end_px;

  always_comb begin
    filt   = |mv[1:0];
    s_pos  = {{(SW-C_W){1'b0}}, pos};
    s_mv   = {{(SW-MV_W){mv[MV_W-1]}}, mv};
    s_int  = s_mv >>> 2;
    s_lead = filt ? SW'(FILTER_LEAD) : '0;
    s_lim  = filt ? SW'(DIM - SPAN_FILTER) : SW'(DIM - SPAN_PLAIN);
    s_raw  = s_pos + s_int - s_lead;

    if (s_raw < 0) begin
      org = '0;
    end else if (s_raw > s_lim) begin
      org = s_lim[C_W-1:0];
    end else begin
      org = s_raw[C_W-1:0];
    end

    end_px   = org + (filt ? C_W'(SPAN_FILTER - 1) : C_W'(SPAN_PLAIN - 1));
    sb_first = org[C_W-1:2];
    sb_last  = end_px[C_W-1:2];
  end

endmodule

// File: rtl/mc_bank_map.sv
// Sub-block coordinates to bank, memory row, sent column and burst.
module mc_bank_map #(
  parameter int SBX_W     = 9,
  parameter int SBY_W     = 9,
  parameter int BANK_BITS = 3,
  parameter int ROW_BITS  = 13,
  parameter int COL_BITS  = 10,
  localparam int CS_W     = COL_BITS - 2
) (
  input  logic [SBY_W-1:0]     sb_row,
  input  logic [SBX_W-1:0]     sb_col_first,
  input  logic [SBX_W-1:0]     sb_col_last,
  output logic [BANK_BITS-1:0] bank,
  output logic [ROW_BITS-1:0]  row,
  output logic [CS_W-1:0]      col,
  output logic [1:0]           burst
);

  logic [SBY_W-1:0] row_full;
  logic [SBX_W-1:0] grp_first;
  logic [SBX_W-1:0] grp_last;
  logic [SBX_W-1:0] grp_diff;

  always_comb begin
    bank      = sb_row[BANK_BITS-1:0];
    row_full  = sb_row >> BANK_BITS;
    row       = ROW_BITS'(row_full);
    grp_first = sb_col_first >> 1;
    grp_last  = sb_col_last >> 1;
    col       = CS_W'(grp_first);
    grp_diff  = grp_last - grp_first;
    burst     = grp_diff[1:0] + 2'd1;
  end

endmodule

// File: rtl/mc_cmd_seq.sv
// Holds one accepted window and walks its sub-block rows top first.
module mc_cmd_seq
  import mc_fetch_pkg::*;
#(
  parameter int SBX_W = 9,
  parameter int SBY_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SBX_W-1:0] in_sx_first,
  input  logic [SBX_W-1:0] in_sx_last,
  input  logic [SBY_W-1:0] in_sy_first,
  input  logic [SBY_W-1:0] in_sy_last,
  input  logic [1:0]       in_px,
  input  logic [1:0]       in_py,
  input  logic             step,
  output logic             idle,
  output logic             issuing,
  output logic             at_last,
  output logic [SBX_W-1:0] sx_first,
  output logic [SBX_W-1:0] sx_last,
  output logic [SBY_W-1:0] sy_cur,
  output logic [1:0]       px,
  output logic [1:0]       py
);

  seq_state_e       st_q, st_d;
  logic [SBY_W-1:0] sy_q, sy_d;
  logic [SBY_W-1:0] sy_end_q;
  logic [SBX_W-1:0] sxf_q, sxl_q;
  logic [1:0]       px_q, py_q;
  logic             load;
  logic             sy_en;

  always_comb begin
    st_d  = st_q;
    sy_d  = sy_q;
    load  = 1'b0;
    sy_en = 1'b0;
    case (st_q)
      SEQ_IDLE: begin
        if (start) begin
          st_d  = SEQ_ISSUE;
          load  = 1'b1;
          sy_en = 1'b1;
          sy_d  = in_sy_first;
        end
      end
      SEQ_ISSUE: begin
        if (step) begin
          if (sy_q == sy_end_q) begin
            st_d = SEQ_IDLE;
          end else begin
            sy_en = 1'b1;
            sy_d  = sy_q + 1'b1;
          end
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SEQ_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy_q <= '0;
    end else if (sy_en) begin
      sy_q <= sy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy_end_q <= '0;
      sxf_q    <= '0;
      sxl_q    <= '0;
      px_q     <= '0;
      py_q     <= '0;
    end else if (load) begin
      sy_end_q <= in_sy_last;
      sxf_q    <= in_sx_first;
      sxl_q    <= in_sx_last;
      px_q     <= in_px;
      py_q     <= in_py;
    end
  end

  assign idle     = (st_q == SEQ_IDLE);
  assign issuing  = (st_q == SEQ_ISSUE);
  assign at_last  = (sy_q == sy_end_q);
  assign sx_first = sxf_q;
  assign sx_last  = sxl_q;
  assign sy_cur   = sy_q;
  assign px       = px_q;
  assign py       = py_q;

endmodule

// File: rtl/mc_ref_fetch_agu.sv
// Reference window fetch address generator, top level.
module mc_ref_fetch_agu #(
  parameter int FRAME_W   = 1920,
  parameter int FRAME_H   = 1088,
  parameter int MV_W      = 12,
  parameter int BANK_BITS = 3,
  parameter int ROW_BITS  = 13,
  parameter int COL_BITS  = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [$clog2(FRAME_W+1)-1:0]  req_blk_x,
  input  logic [$clog2(FRAME_H+1)-1:0]  req_blk_y,
  input  logic [MV_W-1:0]               req_mv_x,
  input  logic [MV_W-1:0]               req_mv_y,
  output logic                          cmd_valid,
  input  logic                          cmd_ready,
  output logic [BANK_BITS-1:0]          cmd_bank,
  output logic [ROW_BITS-1:0]           cmd_row,
  output logic [COL_BITS-3:0]           cmd_col,
  output logic [1:0]                    cmd_burst,
  output logic                          cmd_last,
  output logic                          sel_blk,
  output logic [1:0]                    sel_px,
  output logic [1:0]                    sel_py
);

  localparam int XW    = $clog2(FRAME_W + 1);
  localparam int YW    = $clog2(FRAME_H + 1);
  localparam int SBX_W = XW - 2;
  localparam int SBY_W = YW - 2;

  // Reset: asynchronous assert, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic [XW-1:0]    org_x;
  logic [YW-1:0]    org_y;
  logic [SBX_W-1:0] w_sx_first, w_sx_last;
  logic [SBY_W-1:0] w_sy_first, w_sy_last;

  mc_axis_window #(.DIM(FRAME_W), .MV_W(MV_W)) u_axis_x (
    .pos      (req_blk_x),
    .mv       (req_mv_x),
    .org      (org_x),
    .sb_first (w_sx_first),
    .sb_last  (w_sx_last)
  );

  mc_axis_window #(.DIM(FRAME_H), .MV_W(MV_W)) u_axis_y (
    .pos      (req_blk_y),
    .mv       (req_mv_y),
    .org      (org_y),
    .sb_first (w_sy_first),
    .sb_last  (w_sy_last)
  );

  logic             seq_idle, seq_issue, seq_last;
  logic [SBX_W-1:0] s_sx_first, s_sx_last;
  logic [SBY_W-1:0] s_sy;
  logic [1:0]       s_px, s_py;
  logic             accept;

  assign accept = req_valid && seq_idle;

  mc_cmd_seq #(.SBX_W(SBX_W), .SBY_W(SBY_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start       (accept),
    .in_sx_first (w_sx_first),
    .in_sx_last  (w_sx_last),
    .in_sy_first (w_sy_first),
    .in_sy_last  (w_sy_last),
    .in_px       (org_x[1:0]),
    .in_py       (org_y[1:0]),
    .step        (cmd_ready),
    .idle        (seq_idle),
    .issuing     (seq_issue),
    .at_last     (seq_last),
    .sx_first    (s_sx_first),
    .sx_last     (s_sx_last),
    .sy_cur      (s_sy),
    .px          (s_px),
    .py          (s_py)
  );

  mc_bank_map #(
    .SBX_W(SBX_W), .SBY_W(SBY_W), .BANK_BITS(BANK_BITS),
    .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)
  ) u_map (
    .sb_row       (s_sy),
    .sb_col_first (s_sx_first),
    .sb_col_last  (s_sx_last),
    .bank         (cmd_bank),
    .row          (cmd_row),
    .col          (cmd_col),
    .burst        (cmd_burst)
  );

  assign req_ready = seq_idle;
  assign cmd_valid = seq_issue;
  assign cmd_last  = seq_last;
  assign sel_blk   = s_sx_first[0];
  assign sel_px    = s_px;
  assign sel_py    = s_py;

endmodule

// File: rtl/mc_ref_fetch_agu_chk.sv
module mc_ref_fetch_agu_chk #(
  parameter int FRAME_W   = 1920,
  parameter int FRAME_H   = 1088,
  parameter int BANK_BITS = 3,
  parameter int ROW_BITS  = 13,
  parameter int COL_BITS  = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_ready,
  input logic                 cmd_valid,
  input logic                 cmd_ready,
  input logic [BANK_BITS-1:0] cmd_bank,
  input logic [ROW_BITS-1:0]  cmd_row,
  input logic [COL_BITS-3:0]  cmd_col,
  input logic [1:0]           cmd_burst,
  input logic                 cmd_last,
  input logic                 sel_blk,
  input logic [1:0]           sel_px,
  input logic [1:0]           sel_py
);

  localparam int SB_ROWS = FRAME_H / 4;
  localparam int COL_MAX = ((FRAME_W / 4) - 1) / 2;

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid &&
      $stable({cmd_bank, cmd_row, cmd_col, cmd_burst, cmd_last, sel_blk, sel_px, sel_py}));

  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && cmd_valid));

  p_burst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_burst == 2'd1 || cmd_burst == 2'd2));

  p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && !cmd_last |=> cmd_valid &&
      ({cmd_row, cmd_bank} == $past({cmd_row, cmd_bank}) + 1'b1));

  p_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_last |=> !cmd_valid && req_ready);

  p_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && !cmd_last |=>
      $stable({sel_blk, sel_px, sel_py, cmd_col, cmd_burst}));

  p_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ({cmd_row, cmd_bank} < SB_ROWS) && (cmd_col <= COL_MAX));

endmodule

bind mc_ref_fetch_agu mc_ref_fetch_agu_chk #(
  .FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .BANK_BITS(BANK_BITS),
  .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_bank  (cmd_bank),
  .cmd_row   (cmd_row),
  .cmd_col   (cmd_col),
  .cmd_burst (cmd_burst),
  .cmd_last  (cmd_last),
  .sel_blk   (sel_blk),
  .sel_px    (sel_px),
  .sel_py    (sel_py)
);

// File: tb/mc_ref_fetch_agu_bench.sv
module mc_ref_fetch_agu_bench;

  localparam int CLK_PERIOD = 10;
  localparam int FW   = 128;
  localparam int FH   = 96;
  localparam int MVW  = 12;
  localparam int XW   = $clog2(FW + 1);
  localparam int YW   = $clog2(FH + 1);
  localparam int NVEC = 8;

  // bx, by, mvx, mvy, ncmd, bank0, row0, col, burst, blk, px, py
  localparam int VEC [NVEC][12] = '{
    '{ 16,  8,  0,  0, 1, 2, 0,  2, 1, 0, 0, 0},
    '{ 16,  8,  2,  0, 1, 2, 0,  1, 2, 1, 2, 0},
    '{ 20, 20,  0,  1, 3, 4, 0,  2, 1, 1, 0, 2},
    '{ 32, 28, -3,  6, 3, 6, 0,  3, 2, 1, 1, 3},
    '{  0,  0, -9, -2, 3, 0, 0,  0, 2, 0, 0, 0},
    '{124, 92, 40,  4, 1, 7, 2, 15, 1, 1, 0, 0},
    '{120, 88, 33,  0, 1, 6, 2, 14, 2, 1, 3, 0},
    '{  8,  4,  8, -4, 2, 0, 0,  1, 1, 0, 2, 3}
  };
  // Origin checks of vectors that hit the frame edge are clamp checks.
  localparam string OTAG [NVEC] = '{"R2", "R2", "R2", "R2", "R3", "R3", "R3", "R2"};

  logic           clk;
  logic           rst_n;
  logic           req_valid;
  logic           req_ready;
  logic [XW-1:0]  req_blk_x;
  logic [YW-1:0]  req_blk_y;
  logic [MVW-1:0] req_mv_x;
  logic [MVW-1:0] req_mv_y;
  logic           cmd_valid;
  logic           cmd_ready;
  logic [2:0]     cmd_bank;
  logic [12:0]    cmd_row;
  logic [7:0]     cmd_col;
  logic [1:0]     cmd_burst;
  logic           cmd_last;
  logic           sel_blk;
  logic [1:0]     sel_px;
  logic [1:0]     sel_py;

  int n_checks = 0;
  int n_fail   = 0;

  mc_ref_fetch_agu #(.FRAME_W(FW), .FRAME_H(FH), .MV_W(MVW)) u_mc_ref_fetch_agu (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_blk_x(req_blk_x), .req_blk_y(req_blk_y),
    .req_mv_x(req_mv_x), .req_mv_y(req_mv_y),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .cmd_burst(cmd_burst), .cmd_last(cmd_last),
    .sel_blk(sel_blk), .sel_px(sel_px), .sel_py(sel_py)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // Runs one table vector. stall holds off the first command; noise
  // presents a different request while the stream is pending.
  task automatic run_vec(input int i, input bit stall, input bit noise);
    int sy0;
    @(negedge clk);
    req_valid = 1'b1;
    req_blk_x = XW'(VEC[i][0]);
    req_blk_y = YW'(VEC[i][1]);
    req_mv_x  = MVW'(VEC[i][2]);
    req_mv_y  = MVW'(VEC[i][3]);
    chk(req_ready == 1'b1, "R9", int'(req_ready), 1);
    @(negedge clk);
    if (noise) begin
      req_blk_x = XW'(4);
      req_blk_y = YW'(40);
      req_mv_x  = MVW'(6);
      req_mv_y  = MVW'(-5);
    end else begin
      req_valid = 1'b0;
    end
    sy0 = VEC[i][6] * 8 + VEC[i][5];
    for (int k = 0; k < VEC[i][4]; k++) begin
      chk(cmd_valid == 1'b1, "R4", int'(cmd_valid), 1);
      if (noise) chk(req_ready == 1'b0, "R10", int'(req_ready), 0);
      chk(cmd_bank == 3'((sy0 + k) % 8), "R5", int'(cmd_bank), (sy0 + k) % 8);
      chk(cmd_row == 13'((sy0 + k) / 8), "R5", int'(cmd_row), (sy0 + k) / 8);
      chk(cmd_col == 8'(VEC[i][7]), "R6", int'(cmd_col), VEC[i][7]);
      chk(cmd_burst == 2'(VEC[i][8]), "R7", int'(cmd_burst), VEC[i][8]);
      chk(cmd_last == (k == VEC[i][4] - 1), "R4", int'(cmd_last), int'(k == VEC[i][4] - 1));
      chk(sel_blk == VEC[i][9][0], "R8", int'(sel_blk), VEC[i][9]);
      chk(sel_px == 2'(VEC[i][10]), OTAG[i], int'(sel_px), VEC[i][10]);
      chk(sel_py == 2'(VEC[i][11]), OTAG[i], int'(sel_py), VEC[i][11]);
      if (stall && k == 0) begin
        cmd_ready = 1'b0;
        repeat (3) @(negedge clk);
        chk(cmd_valid == 1'b1, "R9", int'(cmd_valid), 1);
        chk(cmd_bank == 3'(sy0 % 8), "R9", int'(cmd_bank), sy0 % 8);
        chk(cmd_col == 8'(VEC[i][7]), "R9", int'(cmd_col), VEC[i][7]);
      end
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0;
    end
    req_valid = 1'b0;
    // Window size class shows in the exact command count.
    chk(cmd_valid == 1'b0, "R1", int'(cmd_valid), 0);
    chk(req_ready == 1'b1, "R4", int'(req_ready), 1);
  endtask

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    cmd_ready = 1'b0;
    req_blk_x = '0;
    req_blk_y = '0;
    req_mv_x  = '0;
    req_mv_y  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // Reset state.
    chk(cmd_valid == 1'b0, "R9", int'(cmd_valid), 0);
    chk(req_ready == 1'b1, "R9", int'(req_ready), 1);

    // Table walk.
    for (int i = 0; i < NVEC; i++) begin
      run_vec(i, 1'b0, 1'b0);
    end

    // Directed: back-pressure on a three-row vertical window.
    run_vec(2, 1'b1, 1'b0);
    // Directed: request presented while busy across a bank wrap.
    run_vec(3, 1'b0, 1'b1);
    // Directed: stall combined with a busy-time request at the low corner.
    run_vec(4, 1'b1, 1'b1);

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

endmodule